// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a full sprite attribute table of 160 bytes from the CPU address space into sprite attribute RAM. Software starts a copy by writing a page number; that number becomes the high byte of the source address, and the low byte starts at zero. A copy moves one byte at a time on a fixed schedule. The source is read through a read port that the engine owns, and each byte goes to sprite RAM through a dedicated write port.

While a copy is running, the engine sits between the CPU and the system bus. CPU accesses that collide with the copy are refused: reads return 0xFF and writes never reach the bus. Two kinds of address collide. The first is the sprite RAM window itself. The second is a bus window chosen from the 8 KiB region of the source and from the device variant input. When the copy finishes, CPU traffic passes through unchanged.

Top module: `sprite_dma`

## Requirements
- R1: While reset is held and after it is released with no start, `busy` and `spr_we` are 0 and `mem_rd_en` is 0.
- R2: A start whose page is above 0xF1 (base above 0xF100) is ignored whether the engine is idle or copying. Page 0xF1 itself is accepted.
- R3: For an accepted start sampled at clock edge E, the first byte is written at edge E+8. The write strobe is high in the cycle before that edge, with `spr_addr` = 0 and `mem_rd_addr` = page*256.
- R4: Each later byte is written 4 edges after the previous one. `spr_addr` and `mem_rd_addr` both step by one. Exactly 160 writes occur, the last with `spr_addr` = 0x9F.
- R5: In every write cycle, `spr_wdata` equals `mem_rd_data` and `mem_rd_en` is 1.
- R6: `busy` is 1 from the cycle after an accepted start through the cycle of the final write strobe, and 0 from the next cycle. No write strobe occurs while `busy` is 0.
- R7: With `colour_mode` = 0 and `busy` = 1, a source page whose bits [7:5] equal 4 blocks CPU addresses 0x8000–0x9FFF. Any other source region blocks 0xA000–0xFDFF.
- R8: With `colour_mode` = 1 and `busy` = 1, source region 4 blocks 0x8000–0x9FFF and source region 6 blocks 0xC000–0xFDFF. Every other region blocks 0xA000–0xBFFF.
- R9: While `busy` = 1, CPU addresses 0xFE00–0xFE9F are blocked in both variants. For a blocked access, `bus_req` and `bus_we` are 0 and `cpu_rdata` is 0xFF.
- R10: For an access that is not blocked, including every access while `busy` = 0, the bus outputs equal the CPU inputs and `cpu_rdata` equals `bus_rdata`.
- R11: An accepted start while busy abandons the current copy. The copy restarts from the new page with the R3 timing, even when the start coincides with a write cycle; the write in that cycle still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| colour_mode | input | 1 | 1 selects the colour variant's conflict windows |
| start_i | input | 1 | Start strobe |
| start_page_i | input | 8 | Source page (high byte of source address) |
| mem_rd_en | output | 1 | Source read enable |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Source read data, valid in the same cycle |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_addr | output | 8 | Sprite RAM byte offset |
| spr_wdata | output | 8 | Sprite RAM write data |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data returned to the CPU |
| bus_req | output | 1 | Forwarded request |
| bus_we | output | 1 | Forwarded write flag |
| bus_addr | output | 16 | Forwarded address |
| bus_wdata | output | 8 | Forwarded write data |
| bus_rdata | input | 8 | Read data from the bus |
| busy | output | 1 | Copy in progress |

## Verification
CPU gating and the byte mover act in the same cycle all the time. The bench keeps a CPU access on the bus every cycle, sweeping addresses across both window edges and sprite RAM, so accesses land on write cycles as well as idle ones. The sharper case is a new start arriving in exactly the cycle of a byte write. The bench lines the start up with a write strobe it has just observed, four edges later. The reference model is judged on three points: the write in that cycle still happens, the conflict window switches to the new page's region from the next cycle, and the first write of the new copy follows 8 edges later.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - 8;
  localparam int REGION_W = 3;
  localparam logic [REGION_W-1:0] REGION_VIDEO = 3'd4;
  localparam logic [REGION_W-1:0] REGION_WORK = 3'd6;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } sdma_win_t;

  // Inclusive CPU window that collides with a copy from the given source region.
  function automatic sdma_win_t conflict_window(input logic [REGION_W-1:0] region,
                                                input logic colour);
    sdma_win_t w;
    if (region == REGION_VIDEO) begin
      w.lo = 16'h8000; w.hi = 16'h9FFF;
    end else if (colour && region == REGION_WORK) begin
      w.lo = 16'hC000; w.hi = 16'hFDFF;
    end else if (colour) begin
      w.lo = 16'hA000; w.hi = 16'hBFFF;
    end else begin
      w.lo = 16'hA000; w.hi = 16'hFDFF;
    end
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] source_addr(input logic [PAGE_W-1:0] page,
                                                    input logic [7:0] offset);
    return {page, offset};
  endfunction

  function automatic logic [REGION_W-1:0] page_region(input logic [PAGE_W-1:0] page);
    return page[PAGE_W-1 -: REGION_W];
  endfunction
endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer #(
  parameter int XFER_LEN = 160,
  parameter int FIRST_GAP = 8,
  parameter int NEXT_GAP = 4,
  parameter int PAGE_LIMIT = 8'hF1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [sdma_pkg::PAGE_W-1:0]    page_i,
  output logic                           accept_o,
  output logic                           busy_o,
  output logic                           move_o,
  output logic [$clog2(XFER_LEN)-1:0]    idx_o,
  output logic [sdma_pkg::PAGE_W-1:0]    page_o
);
  localparam int IDX_W = $clog2(XFER_LEN);
  localparam int MAX_GAP = (FIRST_GAP > NEXT_GAP) ? FIRST_GAP : NEXT_GAP;
  localparam int GAP_W = $clog2(MAX_GAP + 1);
  localparam logic [GAP_W-1:0] FIRST_RELOAD = GAP_W'(FIRST_GAP - 1);
  localparam logic [GAP_W-1:0] NEXT_RELOAD = GAP_W'(NEXT_GAP - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

  logic                         busy_q;
  logic [GAP_W-1:0]             gap_q;
  logic [IDX_W-1:0]             idx_q;
  logic [sdma_pkg::PAGE_W-1:0]  page_q;
  logic                         last_w;

  assign accept_o = start_i && (int'(page_i) <= PAGE_LIMIT);
  assign move_o   = busy_q && (gap_q == '0);
  assign last_w   = move_o && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= '0;
      idx_q  <= '0;
      page_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      gap_q  <= FIRST_RELOAD;
      idx_q  <= '0;
      page_q <= page_i;
    end else if (move_o) begin
      if (last_w) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        gap_q <= NEXT_RELOAD;
      end
    end else if (busy_q) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign page_o = page_q;
endmodule

// File: rtl/sdma_guard.sv
module sdma_guard #(
  parameter int SPR_BASE = 16'hFE00,
  parameter int SPR_LEN = 160
) (
  input  logic                           busy_i,
  input  logic                           colour_i,
  input  logic [sdma_pkg::REGION_W-1:0]  region_i,
  input  logic                           cpu_req,
  input  logic                           cpu_we,
  input  logic [sdma_pkg::ADDR_W-1:0]    cpu_addr,
  input  logic [sdma_pkg::DATA_W-1:0]    cpu_wdata,
  output logic [sdma_pkg::DATA_W-1:0]    cpu_rdata,
  output logic                           bus_req,
  output logic                           bus_we,
  output logic [sdma_pkg::ADDR_W-1:0]    bus_addr,
  output logic [sdma_pkg::DATA_W-1:0]    bus_wdata,
  input  logic [sdma_pkg::DATA_W-1:0]    bus_rdata,
  output logic                           blocked_o
);
  localparam int AW = sdma_pkg::ADDR_W;
  localparam logic [AW:0] SPR_LO = (AW+1)'(SPR_BASE);
  localparam logic [AW:0] SPR_END = (AW+1)'(SPR_BASE + SPR_LEN);

  sdma_pkg::sdma_win_t win;
  logic in_win, in_spr;

  always_comb begin
    win    = sdma_pkg::conflict_window(region_i, colour_i);
    in_win = (cpu_addr >= win.lo) && (cpu_addr <= win.hi);
    in_spr = ({1'b0, cpu_addr} >= SPR_LO) && ({1'b0, cpu_addr} < SPR_END);
  end

  assign blocked_o = busy_i && (in_win || in_spr);
  assign bus_req   = cpu_req && !blocked_o;
  assign bus_we    = cpu_we && !blocked_o;
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign cpu_rdata = blocked_o ? '1 : bus_rdata;
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int XFER_LEN = 160,
  parameter int FIRST_GAP = 8,
  parameter int NEXT_GAP = 4,
  parameter int PAGE_LIMIT = 8'hF1,
  parameter int SPR_BASE = 16'hFE00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         colour_mode,
  input  logic                         start_i,
  input  logic [7:0]                   start_page_i,
  output logic                         mem_rd_en,
  output logic [15:0]                  mem_rd_addr,
  input  logic [7:0]                   mem_rd_data,
  output logic                         spr_we,
  output logic [$clog2(XFER_LEN)-1:0]  spr_addr,
  output logic [7:0]                   spr_wdata,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  output logic [7:0]                   cpu_rdata,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [15:0]                  bus_addr,
  output logic [7:0]                   bus_wdata,
  input  logic [7:0]                   bus_rdata,
  output logic                         busy
);
  localparam int IDX_W = $clog2(XFER_LEN);

  logic                         accept_w;
  logic                         move_w;
  logic                         blocked_w;
  logic [IDX_W-1:0]             idx_w;
  logic [sdma_pkg::PAGE_W-1:0]  page_w;

  sdma_sequencer #(
    .XFER_LEN(XFER_LEN), .FIRST_GAP(FIRST_GAP),
    .NEXT_GAP(NEXT_GAP), .PAGE_LIMIT(PAGE_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(start_page_i),
    .accept_o(accept_w), .busy_o(busy), .move_o(move_w),
    .idx_o(idx_w), .page_o(page_w)
  );

  sdma_guard #(.SPR_BASE(SPR_BASE), .SPR_LEN(XFER_LEN)) u_guard (
    .busy_i(busy), .colour_i(colour_mode),
    .region_i(sdma_pkg::page_region(page_w)),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blocked_o(blocked_w)
  );

  assign mem_rd_en   = move_w;
  assign mem_rd_addr = sdma_pkg::source_addr(page_w, 8'(idx_w));
  assign spr_we      = move_w;
  assign spr_addr    = idx_w;
  assign spr_wdata   = mem_rd_data;
endmodule

// File: rtl/sdma_checks.sv
module sdma_checks #(
  parameter int XFER_LEN = 160,
  parameter int FIRST_GAP = 8,
  parameter int PAGE_LIMIT = 8'hF1,
  parameter int SPR_BASE = 16'hFE00
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic [7:0]                  start_page_i,
  input logic                        busy,
  input logic                        spr_we,
  input logic [$clog2(XFER_LEN)-1:0] spr_addr,
  input logic [7:0]                  spr_wdata,
  input logic                        mem_rd_en,
  input logic [7:0]                  mem_rd_data,
  input logic                        cpu_req,
  input logic [15:0]                 cpu_addr,
  input logic [7:0]                  cpu_rdata,
  input logic                        bus_req,
  input logic [7:0]                  bus_rdata,
  input logic                        blocked_w
);
  localparam int IDX_W = $clog2(XFER_LEN);
  logic             acc;
  logic [15:0]      since_q;
  logic [IDX_W-1:0] last_q;
  logic             in_spr;

  assign acc    = start_i && (int'(start_page_i) <= PAGE_LIMIT);
  assign in_spr = (int'(cpu_addr) >= SPR_BASE) && (int'(cpu_addr) < SPR_BASE + XFER_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      last_q  <= '0;
    end else begin
      if (acc) since_q <= '0;
      else if (busy) since_q <= since_q + 1'b1;
      if (spr_we) last_q <= spr_addr;
    end
  end

  a_r2_ignore_high_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i && int'(start_page_i) > PAGE_LIMIT) |=> !busy);
  a_r3_first_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && spr_addr == '0) |-> (int'(since_q) == FIRST_GAP - 1));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && spr_addr != '0) |-> (spr_addr == last_q + 1'b1));
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |=> !spr_we);
  a_r5_data_path: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |-> (mem_rd_en && spr_wdata == mem_rd_data));
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spr_we);
  a_r9_sprite_ram_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_req && in_spr) |-> (!bus_req && cpu_rdata == 8'hFF));
  a_r10_pass_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_req == cpu_req && cpu_rdata == bus_rdata && !blocked_w));
endmodule

bind sprite_dma sdma_checks #(
  .XFER_LEN(XFER_LEN), .FIRST_GAP(FIRST_GAP),
  .PAGE_LIMIT(PAGE_LIMIT), .SPR_BASE(SPR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_page_i(start_page_i),
  .busy(busy), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
  .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .cpu_req(cpu_req),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
  .bus_rdata(bus_rdata), .blocked_w(blocked_w)
);

// File: tb/tb_sprite_dma.sv
module tb_sprite_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic colour_mode = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] start_page_i = 8'h00;
  logic mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  logic spr_we;
  logic [7:0] spr_addr;
  logic [7:0] spr_wdata;
  logic cpu_req = 1'b1;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0100;
  logic [7:0] cpu_wdata = 8'h5C;
  logic [7:0] cpu_rdata;
  logic bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign mem_rd_data = mem_rd_addr[7:0] ^ mem_rd_addr[15:8] ^ 8'hA5;
  assign bus_rdata   = cpu_addr[7:0] ^ 8'h3C;

  sprite_dma dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: elapsed edges since the accepted start.
  bit m_busy = 0;
  int m_t = 0;
  int m_base = 0;
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) m_busy = 0;
    else if (start_i && start_page_i <= 8'hF1) begin
      m_busy = 1; m_base = int'(start_page_i) * 256; m_t = 0; wr_cnt = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t > 7 + 4 * 159) m_busy = 0;
    end
  end

  function automatic bit exp_blocked(int a, bit col, int base);
    int region = base / 8192;
    if (a >= 16'hFE00 && a < 16'hFEA0) return 1;   // R9
    if (region == 4) return (a >= 16'h8000 && a < 16'hA000);
    if (col) begin                                   // R8
      if (region == 6) return (a >= 16'hC000 && a < 16'hFE00);
      return (a >= 16'hA000 && a < 16'hC000);
    end
    return (a >= 16'hA000 && a < 16'hFE00);          // R7
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit mv;
      bit blk;
      int idx, sa;
      mv = m_busy && m_t >= 7 && ((m_t - 7) % 4 == 0);
      chk("R6 busy", busy, m_busy);
      chk(m_t == 7 ? "R3 write strobe" : "R4 write strobe", spr_we, mv);
      if (mv) begin
        idx = (m_t - 7) / 4;
        sa = m_base + idx;
        wr_cnt++;
        chk("R4 spr_addr", spr_addr, idx);
        chk("R3 mem_rd_addr", mem_rd_addr, sa);
        chk("R5 rd_en", mem_rd_en, 1);
        chk("R5 spr_wdata", spr_wdata, (sa & 255) ^ (sa >> 8) ^ 8'hA5);
      end
      blk = m_busy && exp_blocked(int'(cpu_addr), colour_mode, m_base);
      if (!m_busy) begin
        chk("R10 bus_req", bus_req, cpu_req);
        chk("R10 cpu_rdata", cpu_rdata, bus_rdata);
      end else if (colour_mode) begin
        chk("R8 bus_req", bus_req, cpu_req && !blk);
        chk("R8 bus_we", bus_we, cpu_we && !blk);
        chk("R8 cpu_rdata", cpu_rdata, blk ? 8'hFF : bus_rdata);
      end else begin
        chk("R7 bus_req", bus_req, cpu_req && !blk);
        chk("R7 bus_we", bus_we, cpu_we && !blk);
        chk("R7 cpu_rdata", cpu_rdata, blk ? 8'hFF : bus_rdata);
      end
      chk("R10 bus_addr", bus_addr, cpu_addr);
    end
  end

  // CPU traffic sweep, changed just after each rising edge
  int k = 0;
  always @(posedge clk) begin
    logic [15:0] lst [12] = '{16'h0100, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF,
                              16'hC000, 16'hFDFF, 16'hFE00, 16'hFE9F, 16'hFEA0, 16'hFF80};
    #1;
    k = (k + 1) % 12;
    cpu_addr  = lst[k];
    cpu_we    = k[0];
    cpu_wdata = 8'(k * 17);
  end

  task automatic kick(input logic [7:0] p);
    @(posedge clk); #1; start_i = 1; start_page_i = p;
    @(posedge clk); #1; start_i = 0;
  endtask

  task automatic full_copy(input bit col, input logic [7:0] p);
    colour_mode = col;
    kick(p);
    repeat (660) @(posedge clk);
    @(negedge clk);
    chk("R4 write count", wr_cnt, 160);
    chk("R6 idle after copy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 spr_we in reset", spr_we, 0);
    chk("R1 rd_en in reset", mem_rd_en, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 busy idle", busy, 0);
    // R2: page above limit while idle
    kick(8'hF2);
    repeat (3) @(negedge clk);
    chk("R2 ignored start", busy, 0);
    full_copy(0, 8'hC0);   // R7 other region
    full_copy(0, 8'h80);   // R7 video region
    full_copy(1, 8'hC0);   // R8 region 6
    full_copy(1, 8'h80);   // R8 region 4
    full_copy(1, 8'hA0);   // R8 other
    full_copy(1, 8'hF1);   // R2 boundary page accepted
    // R11: restart lined up with a write cycle, plus an ignored start mid-copy
    colour_mode = 0;
    kick(8'h10);
    repeat (40) @(posedge clk);
    kick(8'hF5);           // R2 ignored while busy
    @(negedge clk);
    while (!spr_we) @(negedge clk);
    repeat (4) @(posedge clk);
    #1; start_i = 1; start_page_i = 8'h80;
    @(negedge clk);
    chk("R11 write in restart cycle", spr_we, 1);
    @(posedge clk); #1; start_i = 0;
    repeat (660) @(posedge clk);
    @(negedge clk);
    chk("R11 count after restart", wr_cnt, 160);
    chk("R11 idle after restart", busy, 0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule